// File: doc/BRIEF.md
# Memory Read Request Sequencer

This block is the control engine that sits between a slow system-bus slave and a fast DDR memory controller, and it runs entirely on the memory clock. It watches the slave's chip select and read request, pushes read addresses into the controller's address queue while that queue has room, and waits for the controller's read-data-valid strobe. For a single-word read it latches the returned word and acknowledges the bus for two memory clocks. If the synchronized bus clock is high when data arrives, it inserts one idle cycle first, so that the acknowledge lines up with the bus clock phase.

For a burst read the length is given as a number of word pairs. The block pushes twice that many addresses, one per clock, and pauses while the queue is almost full. It then writes every returned word into an external data FIFO by moving between two capture states that take one word each. Once the last word is stored, it raises a handoff level for a separate FIFO drain engine. It holds that level until the drain engine reports that the final word is going out, then returns to idle. The controller, the address generation, the FIFO storage and the drain engine lie outside the block.

Top module: `rd_seq_top`

## Requirements
- R1: A synchronous active-high `rst` puts the block into idle. While `rst` is high and in the first cycle after it falls, `bus_ack`, `fifo_wr` and `drain_go` are 0 and `bus_data` is all zeros.
- R2: In idle, a read is accepted only in a cycle where `cs` and `rd_req` are both 1 and `addr_afull` is 0. `addr_push` is 1 in that same cycle and never in a cycle where `addr_afull` is 1.
- R3: A single read (`burst`=0, or `burst`=1 with `burst_pairs`=0) pushes exactly one address. The block then waits, for any number of cycles, until `ctl_rd_valid` is 1.
- R4: `bus_clk_lvl` passes through a two-flop synchronizer. If the synchronized level is 1 in the cycle where valid data is taken, one empty cycle comes before the acknowledge. If it is 0, the acknowledge starts in the next cycle.
- R5: `bus_ack` is 1 for exactly two consecutive cycles per single read. During both cycles `bus_data` carries the word that was on `ctl_rd_data` when valid was taken. Outside acknowledge cycles `bus_data` is zero.
- R6: While a read is in progress (after acceptance and until idle is reached again), `cs` and `rd_req` have no effect: `addr_push` stays 0 outside the burst address phase.
- R7: A burst read with `burst_pairs`=P>0 pushes exactly 2P addresses. One address goes out in each cycle where `addr_afull` is 0, and pushing pauses in each cycle where it is 1.
- R8: In a burst, each cycle with `ctl_rd_valid`=1 gives `fifo_wr`=1 with `fifo_wdata` equal to `ctl_rd_data`, until 2P words are written. Valid strobes after that are ignored, and a burst never raises `bus_ack`.
- R9: In the cycle after the 2P-th word is written, the block checks that the beat count is spent. `drain_go` is 1 from the cycle after that. It stays 1 until a cycle with `drain_last`=1, and is 0 in the cycle after that.
- R10: The block can start a new read in the cycle after it returns to idle, whether it got there by finishing a read or by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_lvl | input | 1 | Level of the slow bus clock (asynchronous) |
| cs | input | 1 | Slave chip select |
| rd_req | input | 1 | Slave read request |
| burst | input | 1 | 1 = burst read |
| burst_pairs | input | PAIR_W | Burst length in word pairs |
| addr_afull | input | 1 | Controller address queue almost full |
| ctl_rd_valid | input | 1 | Controller read data valid strobe |
| ctl_rd_data | input | DW | Controller read data |
| addr_push | output | 1 | Push one read address to the controller |
| bus_ack | output | 1 | Read acknowledge to the bus slave |
| bus_data | output | DW | Read word to the bus slave |
| fifo_wr | output | 1 | Write one burst word into the data FIFO |
| fifo_wdata | output | DW | Word for the data FIFO |
| drain_go | output | 1 | Handoff level to the FIFO drain engine |
| drain_last | input | 1 | Drain engine is delivering the last burst word |

## Verification
A wrong state register shows up within one or two memory clocks at the ports. A stuck or skipped capture state changes the count of `fifo_wr` pulses. A wrong alignment branch moves the first `bus_ack` by exactly one cycle. A wrong return path shows up as a premature or missing `drain_go` or a third acknowledge cycle. Counter errors surface as the wrong number of `addr_push` or `fifo_wr` pulses per burst, counted against 2P, and as `drain_go` appearing too early or never.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_ALIGN = 3'd2,
        ST_ACK1  = 3'd3,
        ST_ACK2  = 3'd4,
        ST_QUE1  = 3'd5,
        ST_QUE2  = 3'd6,
        ST_DRAIN = 3'd7
    } seq_state_e;

    // per-cycle control strobes from the state machine
    typedef struct packed {
        logic push;        // address to controller
        logic load;        // load burst counters on acceptance
        logic issue_step;  // one more burst address went out
        logic capture;     // burst word into data FIFO
        logic latch;       // single word into holding register
    } seq_ctl_t;

    function automatic logic is_ack_state(seq_state_e s);
        return (s == ST_ACK1) || (s == ST_ACK2);
    endfunction

endpackage

// File: rtl/rdseq_level_sync.sv
module rdseq_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rdseq_counters.sv
module rdseq_counters #(
    parameter int PAIR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAIR_W-1:0] pairs,
    input  logic              addr_step,
    input  logic              beat_step,
    output logic              addr_last,
    output logic              beats_done
);
    localparam int CNT_W = PAIR_W + 1;

    logic [CNT_W-1:0] addr_left;
    logic [CNT_W-1:0] beat_left;
    logic [CNT_W-1:0] words;

    assign words = {pairs, 1'b0};

    // addresses still to push after the one sent with acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_left <= '0;
        end else if (load) begin
            addr_left <= words - CNT_W'(1);
        end else if (addr_step && addr_left != '0) begin
            addr_left <= addr_left - CNT_W'(1);
        end
    end

    // words still expected from the controller
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_left <= '0;
        end else if (load) begin
            beat_left <= words;
        end else if (beat_step && beat_left != '0) begin
            beat_left <= beat_left - CNT_W'(1);
        end
    end

    assign addr_last  = (addr_left == CNT_W'(1));
    assign beats_done = (beat_left == '0);
endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import rdseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       rd_req,
    input  logic       burst,
    input  logic       pairs_nz,
    input  logic       addr_afull,
    input  logic       rd_valid,
    input  logic       bclk_sync,
    input  logic       addr_last,
    input  logic       beats_done,
    input  logic       drain_last,
    output seq_state_e state,
    output seq_ctl_t   ctl
);
    seq_state_e nxt;
    logic       issuing, issuing_n;
    logic       mode_burst, mode_burst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            issuing    <= 1'b0;
            mode_burst <= 1'b0;
        end else begin
            state      <= nxt;
            issuing    <= issuing_n;
            mode_burst <= mode_burst_n;
        end
    end

    always_comb begin
        nxt          = state;
        issuing_n    = issuing;
        mode_burst_n = mode_burst;
        ctl          = '0;
        unique case (state)
            ST_IDLE: begin
                if (issuing) begin
                    if (!addr_afull) begin
                        ctl.push       = 1'b1;
                        ctl.issue_step = 1'b1;
                        if (addr_last) begin
                            issuing_n = 1'b0;
                            nxt       = ST_WAIT;
                        end
                    end
                end else if (cs && rd_req && !addr_afull) begin
                    ctl.push     = 1'b1;
                    ctl.load     = 1'b1;
                    mode_burst_n = burst && pairs_nz;
                    if (burst && pairs_nz) issuing_n = 1'b1;
                    else                   nxt       = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rd_valid) begin
                    if (mode_burst) begin
                        ctl.capture = 1'b1;
                        nxt         = ST_QUE1;
                    end else begin
                        ctl.latch = 1'b1;
                        nxt       = bclk_sync ? ST_ALIGN : ST_ACK1;
                    end
                end
            end
            ST_ALIGN: nxt = ST_ACK1;
            ST_ACK1:  nxt = ST_ACK2;
            ST_ACK2:  nxt = ST_IDLE;
            ST_QUE1: begin
                if (rd_valid) begin
                    ctl.capture = 1'b1;
                    nxt         = ST_QUE2;
                end
            end
            ST_QUE2: begin
                if (beats_done) begin
                    nxt = ST_DRAIN;
                end else if (rd_valid) begin
                    ctl.capture = 1'b1;
                    nxt         = ST_QUE1;
                end
            end
            ST_DRAIN: begin
                if (drain_last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rdseq_hold.sv
module rdseq_hold
    import rdseq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch,
    input  logic [DW-1:0] din,
    input  seq_state_e    state,
    output logic          ack,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)        word_q <= '0;
        else if (latch) word_q <= din;
    end

    assign ack  = is_ack_state(state);
    assign dout = ack ? word_q : '0;
endmodule

// File: rtl/rd_seq_top.sv
module rd_seq_top
    import rdseq_pkg::*;
#(
    parameter int DW     = 32,
    parameter int PAIR_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk_lvl,
    input  logic              cs,
    input  logic              rd_req,
    input  logic              burst,
    input  logic [PAIR_W-1:0] burst_pairs,
    input  logic              addr_afull,
    input  logic              ctl_rd_valid,
    input  logic [DW-1:0]     ctl_rd_data,
    output logic              addr_push,
    output logic              bus_ack,
    output logic [DW-1:0]     bus_data,
    output logic              fifo_wr,
    output logic [DW-1:0]     fifo_wdata,
    output logic              drain_go,
    input  logic              drain_last
);
    seq_state_e state;
    seq_ctl_t   ctl;
    logic       bclk_sync;
    logic       addr_last;
    logic       beats_done;

    rdseq_level_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (bus_clk_lvl),
        .dout (bclk_sync)
    );

    rdseq_counters #(.PAIR_W(PAIR_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (ctl.load),
        .pairs      (burst_pairs),
        .addr_step  (ctl.issue_step),
        .beat_step  (ctl.capture),
        .addr_last  (addr_last),
        .beats_done (beats_done)
    );

    rdseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cs         (cs),
        .rd_req     (rd_req),
        .burst      (burst),
        .pairs_nz   (burst_pairs != '0),
        .addr_afull (addr_afull),
        .rd_valid   (ctl_rd_valid),
        .bclk_sync  (bclk_sync),
        .addr_last  (addr_last),
        .beats_done (beats_done),
        .drain_last (drain_last),
        .state      (state),
        .ctl        (ctl)
    );

    rdseq_hold #(.DW(DW)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .latch (ctl.latch),
        .din   (ctl_rd_data),
        .state (state),
        .ack   (bus_ack),
        .dout  (bus_data)
    );

    assign addr_push  = ctl.push;
    assign fifo_wr    = ctl.capture;
    assign fifo_wdata = ctl_rd_data;
    assign drain_go   = (state == ST_DRAIN);
endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          addr_afull,
    input logic          addr_push,
    input logic          ctl_rd_valid,
    input logic          fifo_wr,
    input logic          bus_ack,
    input logic [DW-1:0] bus_data,
    input logic          drain_go,
    input logic          drain_last
);
    // R2
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        addr_afull |-> !addr_push);

    // R5
    ack_second_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |=> bus_ack);

    // R5
    ack_max_two_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_ack)) |=> !bus_ack);

    // R5
    ack_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_ack)) |-> $stable(bus_data));

    // R5
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (bus_data == '0));

    // R8
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> ctl_rd_valid);

    // R8
    burst_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack && (drain_go || fifo_wr)));

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_go && !drain_last) |=> drain_go);

    // R9
    drain_release_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_go && drain_last) |=> !drain_go);
endmodule

bind rd_seq_top rdseq_checker #(.DW(DW)) u_rdseq_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_afull   (addr_afull),
    .addr_push    (addr_push),
    .ctl_rd_valid (ctl_rd_valid),
    .fifo_wr      (fifo_wr),
    .bus_ack      (bus_ack),
    .bus_data     (bus_data),
    .drain_go     (drain_go),
    .drain_last   (drain_last)
);

// File: tb/test_rd_seq_top.sv
`timescale 1ns/1ps
module test_rd_seq_top;
    localparam int DW     = 32;
    localparam int PAIR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_clk_lvl = 1'b0;
    logic              cs = 1'b0, rd_req = 1'b0, burst = 1'b0;
    logic [PAIR_W-1:0] burst_pairs = '0;
    logic              addr_afull = 1'b0;
    logic              ctl_rd_valid = 1'b0;
    logic [DW-1:0]     ctl_rd_data = '0;
    logic              drain_last = 1'b0;
    logic              addr_push, bus_ack, fifo_wr, drain_go;
    logic [DW-1:0]     bus_data, fifo_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rd_seq_top #(.DW(DW), .PAIR_W(PAIR_W)) i_rd_seq_top (
        .clk, .rst, .bus_clk_lvl, .cs, .rd_req, .burst, .burst_pairs,
        .addr_afull, .ctl_rd_valid, .ctl_rd_data, .addr_push, .bus_ack,
        .bus_data, .fifo_wr, .fifo_wdata, .drain_go, .drain_last
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected length of the empty gap before acknowledge (R4)
    function automatic int gap_cycles(input bit lvl);
        return lvl ? 1 : 0;
    endfunction

    function automatic int burst_words(input int pairs);
        return 2 * pairs;
    endfunction

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic single_read(input bit lvl, input bit use_pairs0,
                               input int delay, input logic [DW-1:0] word);
        bus_clk_lvl = lvl;
        repeat (3) nedge();
        cs = 1; rd_req = 1; burst = use_pairs0; burst_pairs = '0;
        #1;
        chk(addr_push == 1'b1, "R2 accept push", addr_push, 1);
        nedge();
        burst = 0;
        #1;
        chk(addr_push == 1'b0, "R6 request ignored while waiting", addr_push, 0);
        for (int i = 0; i < delay; i++) begin
            nedge();
            #1;
            chk(bus_ack == 1'b0, "R3 no ack before valid", bus_ack, 0);
        end
        nedge();
        ctl_rd_valid = 1; ctl_rd_data = word;
        nedge();
        ctl_rd_valid = 0; ctl_rd_data = ~word;
        for (int g = 0; g < gap_cycles(lvl); g++) begin
            #1;
            chk(bus_ack == 1'b0, "R4 align gap", bus_ack, 0);
            nedge();
        end
        #1;
        chk(bus_ack == 1'b1, "R4 ack start", bus_ack, 1);
        chk(bus_data == word, "R5 data cycle1", bus_data, word);
        chk(addr_push == 1'b0, "R6 no push during ack", addr_push, 0);
        nedge();
        #1;
        chk(bus_ack == 1'b1, "R5 ack cycle2", bus_ack, 1);
        chk(bus_data == word, "R5 data cycle2", bus_data, word);
        cs = 0; rd_req = 0;
        nedge();
        #1;
        chk(bus_ack == 1'b0, "R5 ack ends", bus_ack, 0);
        chk(bus_data == '0, "R5 data zero", bus_data, 0);
    endtask

    task automatic burst_read(input int pairs, input int full_pct);
        int total, pushed, captured, hold;
        total = burst_words(pairs);
        repeat (2) nedge();
        cs = 1; rd_req = 1; burst = 1; burst_pairs = PAIR_W'(pairs);
        #1;
        chk(addr_push == 1'b1, "R7 first push", addr_push, 1);
        pushed = 1;
        while (pushed < total) begin
            nedge();
            cs = 0; rd_req = 0;
            addr_afull = (($urandom % 100) < full_pct);
            #1;
            chk(addr_push == !addr_afull, "R7 push follows room", addr_push, !addr_afull);
            if (addr_push) pushed++;
        end
        nedge();
        addr_afull = 0; cs = 1; rd_req = 1; burst = 0;
        #1;
        chk(addr_push == 1'b0, "R7 exactly 2P pushes", addr_push, 0);
        captured = 0;
        while (captured < total) begin
            ctl_rd_valid = $urandom % 2;
            ctl_rd_data  = $urandom;
            #1;
            chk(fifo_wr == ctl_rd_valid, "R8 write on valid", fifo_wr, ctl_rd_valid);
            if (fifo_wr) begin
                chk(fifo_wdata == ctl_rd_data, "R8 write data", fifo_wdata, ctl_rd_data);
                captured++;
            end
            chk(bus_ack == 1'b0, "R8 no ack in burst", bus_ack, 0);
            chk(addr_push == 1'b0, "R6 no push in burst", addr_push, 0);
            nedge();
        end
        ctl_rd_valid = 1; ctl_rd_data = 32'hDEAD_BEEF;
        #1;
        chk(fifo_wr == 1'b0, "R8 extra valid ignored", fifo_wr, 0);
        chk(drain_go == 1'b0, "R9 drain not yet", drain_go, 0);
        nedge();
        ctl_rd_valid = 0;
        hold = 1 + ($urandom % 4);
        for (int h = 0; h < hold; h++) begin
            #1;
            chk(drain_go == 1'b1, "R9 drain held", drain_go, 1);
            chk(fifo_wr == 1'b0 && bus_ack == 1'b0, "R8 quiet during drain", {fifo_wr, bus_ack}, 0);
            nedge();
        end
        drain_last = 1;
        nedge();
        drain_last = 0; cs = 0; rd_req = 0;
        #1;
        chk(drain_go == 1'b0, "R9 drain released", drain_go, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) nedge();
        #1;
        // R1 outputs quiet during reset
        chk({bus_ack, fifo_wr, drain_go} == 3'b000, "R1 in reset", {bus_ack, fifo_wr, drain_go}, 0);
        chk(bus_data == '0, "R1 data in reset", bus_data, 0);
        rst = 0;
        nedge();
        #1;
        chk({bus_ack, fifo_wr, drain_go, addr_push} == 4'b0000, "R1 after reset",
            {bus_ack, fifo_wr, drain_go, addr_push}, 0);

        // R2 almost-full blocks acceptance
        cs = 1; rd_req = 1; addr_afull = 1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(addr_push == 1'b0, "R2 blocked by afull", addr_push, 0);
            nedge();
        end
        addr_afull = 0; rd_req = 0;
        #1;
        chk(addr_push == 1'b0, "R2 needs rd_req", addr_push, 0);
        cs = 0; rd_req = 1;
        #1;
        chk(addr_push == 1'b0, "R2 needs cs", addr_push, 0);
        rd_req = 0;

        // directed single reads: both alignment branches, zero and long delay
        single_read(1'b0, 1'b0, 0, 32'h1234_5678);
        single_read(1'b1, 1'b0, 0, 32'hA5A5_0F0F);
        single_read(1'b1, 1'b1, 5, 32'h0BAD_CAFE);   // R3 burst with zero pairs
        // directed bursts: shortest, longest, heavy backpressure
        burst_read(1, 0);
        burst_read((1 << PAIR_W) - 1, 20);
        burst_read(3, 70);
        // R10 back-to-back right after drain
        single_read(1'b0, 1'b0, 1, 32'hFFFF_0001);

        // R10 reset in the middle of a read
        bus_clk_lvl = 0;
        nedge();
        cs = 1; rd_req = 1; burst = 0;
        nedge();
        cs = 0; rd_req = 0;
        rst = 1;
        nedge();
        rst = 0;
        ctl_rd_valid = 1; ctl_rd_data = 32'h7777_7777;
        nedge();
        ctl_rd_valid = 0;
        #1;
        chk(bus_ack == 1'b0, "R10 reset aborts read", bus_ack, 0);
        single_read(1'b0, 1'b0, 2, 32'h1357_9BDF);

        // random mix
        for (int t = 0; t < 40; t++) begin
            if ($urandom % 2)
                single_read($urandom % 2, 1'b0, $urandom % 6, $urandom);
            else
                burst_read(1 + ($urandom % ((1 << PAIR_W) - 1)), $urandom % 60);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule